// File: doc/BRIEF.md
# Two-Page Shared RAM with Fixed-Priority Bus Arbitration

This block is a banked on-chip memory split into two pages, each with one read port and one write port that work independently. Three requesters share it: a DMA-side system bus, a CPU data bus and a CPU instruction-fetch bus. The fetch bus can only read. The page is picked from the byte address. Each page has its own fixed-priority arbiter on its read port and another on its write port, so accesses to different pages, or a read and a write to one page, finish in the same cycle.

Every bus uses a request/ready handshake. `ready` is combinational and is high in the cycle the access is granted. A bus that loses arbitration keeps its request and its fields steady until `ready` rises. Read data comes back on the bus's `rdata` one clock after the grant.

Two control vectors, driven from outside, gate the pages. One switches a page on or off. The other allows or blocks writes to a page. Accesses to a switched-off page are still acknowledged. Such an access raises an error flag and never touches storage.

Top module: `pgram_hub`

## Requirements
- R1: A byte address in 0xFFF80000..0xFFF83FFF selects page 0 and one in 0xFFF84000..0xFFF87FFF selects page 1. The word inside the page is address bits [13:2]. An address outside both ranges is never acknowledged (`ready` stays low) and has no effect.
- R2: `rdata` of a bus is all zeros in any cycle that does not follow a granted read by that bus.
- R3: A granted write updates the addressed word at the clock edge that ends the grant cycle. Strobe bit i enables byte lane i (data bits 8i+7..8i). Lanes with a clear strobe keep their old value.
- R4: When several buses want the same port of the same page in one cycle, exactly one is granted, in the order DMA bus, then CPU data bus, then fetch bus. Losers see `ready` low, and a loser that holds its request is granted once the winner is gone.
- R5: Requests that go to different pages, or a read and a write to the same page, are all granted in the same cycle.
- R6: The fetch bus uses only read ports. A fetch is never stalled by a write from another bus.
- R7: When a page's write-enable bit (`page_wen[p]`) is 0, a write to that page is acknowledged with `err` low, and the stored word is left unchanged.
- R8: When a page's enable bit (`page_en[p]`) is 0, any access to that page is acknowledged with `err` high in the grant cycle. A read returns all zeros and a write is dropped. `err` is never high without `ready`.
- R9: When one bus reads a word and another writes the same word in the same cycle, the read returns the value from before the write.
- R10: While reset (`rst_n` low, asynchronous) is asserted and right after it, every `rdata` is zero. Asserting reset clears pending read data at once. `ready` and `err` stay low when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_en | input | 2 | Per-page operation enable |
| page_wen | input | 2 | Per-page write enable |
| dma_req | input | 1 | DMA bus request |
| dma_we | input | 1 | DMA bus write (1) or read (0) |
| dma_addr | input | 32 | DMA bus byte address |
| dma_wdata | input | 32 | DMA bus write data |
| dma_be | input | 4 | DMA bus byte strobes |
| dma_ready | output | 1 | DMA bus grant in this cycle |
| dma_rdata | output | 32 | DMA bus read data (cycle after grant) |
| dma_err | output | 1 | DMA access to a disabled page |
| cpu_req | input | 1 | CPU data bus request |
| cpu_we | input | 1 | CPU data bus write (1) or read (0) |
| cpu_addr | input | 32 | CPU data bus byte address |
| cpu_wdata | input | 32 | CPU data bus write data |
| cpu_be | input | 4 | CPU data bus byte strobes |
| cpu_ready | output | 1 | CPU data bus grant in this cycle |
| cpu_rdata | output | 32 | CPU data bus read data |
| cpu_err | output | 1 | CPU data access to a disabled page |
| ifu_req | input | 1 | Fetch bus read request |
| ifu_addr | input | 32 | Fetch bus byte address |
| ifu_ready | output | 1 | Fetch bus grant in this cycle |
| ifu_rdata | output | 32 | Fetch bus read data |
| ifu_err | output | 1 | Fetch access to a disabled page |

## Verification
The bench puts all three buses on one read port and checks that only the top-priority bus is acknowledged. A reversed or missing priority would acknowledge two buses or the wrong one. It fetches a word in the same cycle that DMA writes it. A design that forwarded the write would return the new data, and one that arbitrated fetches against writes would stall the fetch. It also probes the addresses just outside each end of the window and the last word of page 1. A sloppy decode would acknowledge the stray accesses or alias the top word. Disabled and write-protected pages are read back afterwards to show that the dropped writes left storage untouched, and a sub-word strobe write shows that lanes with a clear strobe kept their old bytes.

// File: rtl/pgram_pkg.sv
`timescale 1ns/1ps
package pgram_pkg;

    // number of pages and the address bits that select one
    localparam int NPAGE = 2;
    localparam int PSW   = (NPAGE > 1) ? $clog2(NPAGE) : 1;

    // requesters; the index order is also the priority order
    localparam int NBUS    = 3;
    localparam int BUS_DMA = 0;
    localparam int BUS_CPU = 1;
    localparam int BUS_IFU = 2;

    // per-bus read return tracking
    typedef struct packed {
        logic           vld;   // a read was granted last cycle
        logic           zero;  // that read hit a disabled page
        logic [PSW-1:0] page;  // page whose read register holds the data
    } rtn_t;

endpackage

// File: rtl/pgram_decode.sv
`timescale 1ns/1ps
module pgram_decode
    import pgram_pkg::*;
#(
    parameter logic [31:0] BASE    = 32'hFFF8_0000,
    parameter int          PAGE_AW = 14,
    parameter int          WAW     = 12
) (
    input  logic [31:0]    addr,
    output logic           hit,
    output logic [PSW-1:0] page,
    output logic [WAW-1:0] word
);
    localparam int          TOP_LSB = PAGE_AW + PSW;
    localparam int          BSH     = PAGE_AW - WAW;
    localparam logic [31:0] LAST    = BASE + ((32'(NPAGE) << PAGE_AW) - 32'd1);

    logic unused_lo;

    always_comb begin
        hit       = (addr[31:TOP_LSB] == BASE[31:TOP_LSB]);
        page      = addr[PAGE_AW +: PSW];
        word      = addr[BSH +: WAW];
        unused_lo = ^addr[BSH-1:0];
    end

    // a claimed address must lie inside the configured window
    always_comb begin
        assert_hit_in_window_R1: assert (!hit || (addr >= BASE && addr <= LAST));
    end

endmodule

// File: rtl/pgram_prio_arb.sv
`timescale 1ns/1ps
module pgram_prio_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // index 0 has the highest priority: keep the lowest set bit
    always_comb begin
        gnt = req & (~req + N'(1));
    end

    always_comb begin
        assert_grant_onehot_R4: assert ($onehot0(gnt));
        assert_grant_subset_R4: assert ((gnt & ~req) == '0);
        assert_grant_top_R4:    assert (!req[0] || gnt[0]);
        assert_grant_any_R4:    assert ((req == '0) || (gnt != '0));
    end

endmodule

// File: rtl/pgram_bank.sv
`timescale 1ns/1ps
module pgram_bank #(
    parameter int DW  = 32,
    parameter int WAW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            re,
    input  logic [WAW-1:0]  raddr,
    output logic [DW-1:0]   rdata,
    input  logic            we,
    input  logic [WAW-1:0]  waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [DW/8-1:0] be
);
    localparam int BEW   = DW / 8;
    localparam int DEPTH = 1 << WAW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_d, rd_q;

    // read register picks up the word as it was before this edge's write
    always_comb begin
        rd_d = re ? mem[raddr] : rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < BEW; i++) begin
                if (be[i]) begin
                    mem[waddr][8*i +: 8] <= wdata[8*i +: 8];
                end
            end
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/pgram_hub.sv
`timescale 1ns/1ps
module pgram_hub
    import pgram_pkg::*;
#(
    parameter int          DW      = 32,
    parameter logic [31:0] BASE    = 32'hFFF8_0000,
    parameter int          PAGE_AW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPAGE-1:0]  page_en,
    input  logic [NPAGE-1:0]  page_wen,
    input  logic              dma_req,
    input  logic              dma_we,
    input  logic [31:0]       dma_addr,
    input  logic [DW-1:0]     dma_wdata,
    input  logic [DW/8-1:0]   dma_be,
    output logic              dma_ready,
    output logic [DW-1:0]     dma_rdata,
    output logic              dma_err,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [31:0]       cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic [DW/8-1:0]   cpu_be,
    output logic              cpu_ready,
    output logic [DW-1:0]     cpu_rdata,
    output logic              cpu_err,
    input  logic              ifu_req,
    input  logic [31:0]       ifu_addr,
    output logic              ifu_ready,
    output logic [DW-1:0]     ifu_rdata,
    output logic              ifu_err
);
    localparam int BEW = DW / 8;
    localparam int WAW = PAGE_AW - $clog2(BEW);

    typedef struct packed {
        rtn_t [NBUS-1:0] rtn;
    } hub_state_t;

    // bus fields gathered into arrays indexed by priority
    logic [NBUS-1:0] req, wr;
    logic [31:0]     addr [NBUS];
    logic [DW-1:0]   wd   [NBUS];
    logic [BEW-1:0]  be   [NBUS];

    logic [NBUS-1:0] hit;
    logic [PSW-1:0]  pg   [NBUS];
    logic [WAW-1:0]  wix  [NBUS];

    logic [NPAGE-1:0][NBUS-1:0] rgnt, wgnt;
    logic [NPAGE-1:0][DW-1:0]   bank_rd;

    logic [NBUS-1:0] rdy, rdg, err;
    logic [DW-1:0]   rdo [NBUS];

    hub_state_t state_d, state_q;

    always_comb begin
        req = {ifu_req, cpu_req, dma_req};
        wr  = {1'b0, cpu_we, dma_we};
        addr[BUS_DMA] = dma_addr;
        addr[BUS_CPU] = cpu_addr;
        addr[BUS_IFU] = ifu_addr;
        wd[BUS_DMA]   = dma_wdata;
        wd[BUS_CPU]   = cpu_wdata;
        wd[BUS_IFU]   = '0;
        be[BUS_DMA]   = dma_be;
        be[BUS_CPU]   = cpu_be;
        be[BUS_IFU]   = '0;
    end

    // address decode per bus
    for (genvar b = 0; b < NBUS; b++) begin : g_dec
        pgram_decode #(
            .BASE    (BASE),
            .PAGE_AW (PAGE_AW),
            .WAW     (WAW)
        ) u_dec (
            .addr (addr[b]),
            .hit  (hit[b]),
            .page (pg[b]),
            .word (wix[b])
        );
    end

    // one read arbiter, one write arbiter and one storage array per page
    for (genvar p = 0; p < NPAGE; p++) begin : g_page
        logic [NBUS-1:0] rq, wq;
        logic            re, we;
        logic [WAW-1:0]  ra, wa;
        logic [DW-1:0]   wdat;
        logic [BEW-1:0]  wbe;

        always_comb begin
            rq = '0;
            wq = '0;
            for (int b = 0; b < NBUS; b++) begin
                rq[b] = req[b] & hit[b] & (pg[b] == PSW'(p)) & ~wr[b];
                wq[b] = req[b] & hit[b] & (pg[b] == PSW'(p)) &  wr[b];
            end
        end

        pgram_prio_arb #(.N(NBUS)) u_rarb (.req(rq), .gnt(rgnt[p]));
        pgram_prio_arb #(.N(NBUS)) u_warb (.req(wq), .gnt(wgnt[p]));

        always_comb begin
            ra   = '0;
            wa   = '0;
            wdat = '0;
            wbe  = '0;
            for (int b = 0; b < NBUS; b++) begin
                if (rgnt[p][b]) begin
                    ra = wix[b];
                end
                if (wgnt[p][b]) begin
                    wa   = wix[b];
                    wdat = wd[b];
                    wbe  = be[b];
                end
            end
            re = (|rgnt[p]) & page_en[p];
            we = (|wgnt[p]) & page_en[p] & page_wen[p];
        end

        pgram_bank #(
            .DW  (DW),
            .WAW (WAW)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .re    (re),
            .raddr (ra),
            .rdata (bank_rd[p]),
            .we    (we),
            .waddr (wa),
            .wdata (wdat),
            .be    (wbe)
        );
    end

    // acknowledge, error and next return state
    always_comb begin
        state_d = state_q;
        for (int b = 0; b < NBUS; b++) begin
            rdy[b] = 1'b0;
            rdg[b] = 1'b0;
            for (int p = 0; p < NPAGE; p++) begin
                rdy[b] = rdy[b] | rgnt[p][b] | wgnt[p][b];
                rdg[b] = rdg[b] | rgnt[p][b];
            end
            err[b] = rdy[b] & ~page_en[pg[b]];
            state_d.rtn[b].vld  = rdg[b];
            state_d.rtn[b].zero = ~page_en[pg[b]];
            state_d.rtn[b].page = pg[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        for (int b = 0; b < NBUS; b++) begin
            rdo[b] = (state_q.rtn[b].vld && !state_q.rtn[b].zero)
                   ? bank_rd[state_q.rtn[b].page] : '0;
        end
    end

    assign dma_ready = rdy[BUS_DMA];
    assign cpu_ready = rdy[BUS_CPU];
    assign ifu_ready = rdy[BUS_IFU];
    assign dma_err   = err[BUS_DMA];
    assign cpu_err   = err[BUS_CPU];
    assign ifu_err   = err[BUS_IFU];
    assign dma_rdata = rdo[BUS_DMA];
    assign cpu_rdata = rdo[BUS_CPU];
    assign ifu_rdata = rdo[BUS_IFU];

    // ---------------- assertions ----------------
    logic [NBUS-1:0] rdy_v, err_v;
    assign rdy_v = {ifu_ready, cpu_ready, dma_ready};
    assign err_v = {ifu_err, cpu_err, dma_err};

    assert_unclaimed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req & ~hit & rdy_v) == '0);

    assert_dma_never_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && hit[BUS_DMA]) |-> dma_ready);

    assert_cpu_stall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && hit[BUS_CPU] && !cpu_ready) |->
        (dma_req && hit[BUS_DMA] && pg[BUS_DMA] == pg[BUS_CPU] && dma_we == cpu_we));

    assert_ifu_stall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ifu_req && hit[BUS_IFU] && !ifu_ready) |->
        ((dma_req && hit[BUS_DMA] && !dma_we && pg[BUS_DMA] == pg[BUS_IFU]) ||
         (cpu_req && hit[BUS_CPU] && !cpu_we && pg[BUS_CPU] == pg[BUS_IFU])));

    assert_err_needs_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_v & ~rdy_v) == '0);

    assert_off_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !cpu_we && cpu_err) |=> (cpu_rdata == '0));

    assert_idle_rdata_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_ready && !dma_we) |=> (dma_rdata == '0));

endmodule

// File: tb/pgram_hub_tb_top.sv
`timescale 1ns/1ps
module pgram_hub_tb_top;

    localparam int CLK_PER = 20;   // 50 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  page_en = 2'b11, page_wen = 2'b11;
    logic        dma_req = 0, dma_we = 0, cpu_req = 0, cpu_we = 0, ifu_req = 0;
    logic [31:0] dma_addr = 0, dma_wdata = 0, cpu_addr = 0, cpu_wdata = 0, ifu_addr = 0;
    logic [3:0]  dma_be = 0, cpu_be = 0;
    logic        dma_ready, cpu_ready, ifu_ready, dma_err, cpu_err, ifu_err;
    logic [31:0] dma_rdata, cpu_rdata, ifu_rdata;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PER/2) clk = ~clk;

    pgram_hub dut_i (
        .clk(clk), .rst_n(rst_n), .page_en(page_en), .page_wen(page_wen),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .dma_be(dma_be), .dma_ready(dma_ready), .dma_rdata(dma_rdata), .dma_err(dma_err),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_be(cpu_be), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err),
        .ifu_req(ifu_req), .ifu_addr(ifu_addr), .ifu_ready(ifu_ready),
        .ifu_rdata(ifu_rdata), .ifu_err(ifu_err)
    );

    typedef struct packed {
        logic        d_req, d_we; logic [31:0] d_addr, d_wd; logic [3:0] d_be;
        logic        c_req, c_we; logic [31:0] c_addr, c_wd; logic [3:0] c_be;
        logic        f_req;       logic [31:0] f_addr;
        logic [1:0]  en, wen;
        logic [2:0]  x_rdy, x_err, x_rchk;   // bit0 dma, bit1 cpu, bit2 fetch
        logic [31:0] x_d, x_c, x_f;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        // R3 R5: writes to both pages in one cycle
        '{1,1,32'hFFF80010,32'hAAAA5555,4'hF, 1,1,32'hFFF84020,32'h12345678,4'hF, 0,32'h0,
          2'b11,2'b11, 3'b011,3'b000,3'b000, 32'h0,32'h0,32'h0, 4'd5},
        // R4: all three read one word of page 0, DMA wins
        '{1,0,32'hFFF80010,32'h0,4'h0, 1,0,32'hFFF80010,32'h0,4'h0, 1,32'hFFF80010,
          2'b11,2'b11, 3'b001,3'b000,3'b001, 32'hAAAA5555,32'h0,32'h0, 4'd4},
        // R4: CPU data beats fetch
        '{0,0,32'h0,32'h0,4'h0, 1,0,32'hFFF80010,32'h0,4'h0, 1,32'hFFF80010,
          2'b11,2'b11, 3'b010,3'b000,3'b010, 32'h0,32'hAAAA5555,32'h0, 4'd4},
        // R9 R6: fetch reads a word DMA writes (low lanes) in the same cycle
        '{1,1,32'hFFF84020,32'hDEADBEEF,4'h3, 1,0,32'hFFF80010,32'h0,4'h0, 1,32'hFFF84020,
          2'b11,2'b11, 3'b111,3'b000,3'b110, 32'h0,32'hAAAA5555,32'h12345678, 4'd9},
        // R3: lane-merged result visible
        '{0,0,32'h0,32'h0,4'h0, 1,1,32'hFFF80014,32'h01020304,4'hF, 1,32'hFFF84020,
          2'b11,2'b11, 3'b110,3'b000,3'b100, 32'h0,32'h0,32'h1234BEEF, 4'd3},
        // R3: single lane write (lane 2)
        '{1,1,32'hFFF80014,32'hFFFFFFFF,4'h4, 1,0,32'hFFF84020,32'h0,4'h0, 0,32'h0,
          2'b11,2'b11, 3'b011,3'b000,3'b010, 32'h0,32'h1234BEEF,32'h0, 4'd3},
        '{1,0,32'hFFF80014,32'h0,4'h0, 0,0,32'h0,32'h0,4'h0, 0,32'h0,
          2'b11,2'b11, 3'b001,3'b000,3'b001, 32'h01FF0304,32'h0,32'h0, 4'd3},
        // R7: page 0 write-protected
        '{0,0,32'h0,32'h0,4'h0, 1,1,32'hFFF80014,32'h0,4'hF, 0,32'h0,
          2'b11,2'b10, 3'b010,3'b000,3'b000, 32'h0,32'h0,32'h0, 4'd7},
        '{0,0,32'h0,32'h0,4'h0, 1,0,32'hFFF80014,32'h0,4'h0, 0,32'h0,
          2'b11,2'b11, 3'b010,3'b000,3'b010, 32'h0,32'h01FF0304,32'h0, 4'd7},
        // R8: page 1 switched off
        '{1,0,32'hFFF84020,32'h0,4'h0, 1,1,32'hFFF84020,32'h0,4'hF, 1,32'hFFF80010,
          2'b01,2'b11, 3'b111,3'b011,3'b101, 32'h0,32'h0,32'hAAAA5555, 4'd8},
        '{0,0,32'h0,32'h0,4'h0, 0,0,32'h0,32'h0,4'h0, 1,32'hFFF84020,
          2'b11,2'b11, 3'b100,3'b000,3'b100, 32'h0,32'h0,32'h1234BEEF, 4'd8},
        // R1: just above and just below the window, last word of page 1
        '{1,0,32'hFFF88000,32'h0,4'h0, 1,0,32'hFFF7FFFC,32'h0,4'h0, 1,32'hFFF87FFC,
          2'b11,2'b11, 3'b100,3'b000,3'b011, 32'h0,32'h0,32'h0, 4'd1},
        '{1,1,32'hFFF87FFC,32'hCAFEF00D,4'hF, 0,0,32'h0,32'h0,4'h0, 0,32'h0,
          2'b11,2'b11, 3'b001,3'b000,3'b000, 32'h0,32'h0,32'h0, 4'd1},
        '{1,0,32'hFFF80010,32'h0,4'h0, 0,0,32'h0,32'h0,4'h0, 1,32'hFFF87FFC,
          2'b11,2'b11, 3'b101,3'b000,3'b101, 32'hAAAA5555,32'h0,32'hCAFEF00D, 4'd1},
        // R2: idle cycle, all read data back to zero
        '{0,0,32'h0,32'h0,4'h0, 0,0,32'h0,32'h0,4'h0, 0,32'h0,
          2'b11,2'b11, 3'b000,3'b000,3'b111, 32'h0,32'h0,32'h0, 4'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        dma_req = v.d_req; dma_we = v.d_we; dma_addr = v.d_addr; dma_wdata = v.d_wd; dma_be = v.d_be;
        cpu_req = v.c_req; cpu_we = v.c_we; cpu_addr = v.c_addr; cpu_wdata = v.c_wd; cpu_be = v.c_be;
        ifu_req = v.f_req; ifu_addr = v.f_addr;
        page_en = v.en; page_wen = v.wen;
    endtask

    task automatic idle();
        dma_req = 0; dma_we = 0; cpu_req = 0; cpu_we = 0; ifu_req = 0;
        page_en = 2'b11; page_wen = 2'b11;
    endtask

    task automatic check_ack(input vec_t v, input int i);
        chk($sformatf("R%0d vec%0d ready", v.rq, i), {29'd0, ifu_ready, cpu_ready, dma_ready}, {29'd0, v.x_rdy});
        chk($sformatf("R%0d vec%0d err", v.rq, i), {29'd0, ifu_err, cpu_err, dma_err}, {29'd0, v.x_err});
    endtask

    task automatic check_rd(input vec_t v, input int i);
        if (v.x_rchk[0]) chk($sformatf("R%0d vec%0d dma rdata", v.rq, i), dma_rdata, v.x_d);
        if (v.x_rchk[1]) chk($sformatf("R%0d vec%0d cpu rdata", v.rq, i), cpu_rdata, v.x_c);
        if (v.x_rchk[2]) chk($sformatf("R%0d vec%0d fetch rdata", v.rq, i), ifu_rdata, v.x_f);
    endtask

    initial begin
        #(CLK_PER * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 ready in reset", {29'd0, ifu_ready, cpu_ready, dma_ready}, 32'd0);
        chk("R10 err in reset", {29'd0, ifu_err, cpu_err, dma_err}, 32'd0);
        chk("R10 rdata in reset", dma_rdata | cpu_rdata | ifu_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 rdata after reset", dma_rdata | cpu_rdata | ifu_rdata, 32'd0);

        // table walk: ack checked in the drive cycle, rdata one cycle later
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (i > 0) check_rd(VT[i-1], i - 1);
            drive(VT[i]);
            #2;
            check_ack(VT[i], i);
        end
        @(negedge clk);
        check_rd(VT[NV-1], NV - 1);
        idle();

        // R4: a stalled CPU read held over and granted once DMA leaves
        @(negedge clk);
        dma_req = 1; dma_we = 0; dma_addr = 32'hFFF80014;
        cpu_req = 1; cpu_we = 0; cpu_addr = 32'hFFF80010;
        #2;
        chk("R4 cpu stalled behind dma", {31'd0, cpu_ready}, 32'd0);
        @(negedge clk);
        chk("R4 dma read data", dma_rdata, 32'h01FF0304);
        dma_req = 0;
        #2;
        chk("R4 cpu granted after hold", {31'd0, cpu_ready}, 32'd1);
        @(negedge clk);
        chk("R4 cpu held read data", cpu_rdata, 32'hAAAA5555);
        idle();

        // R10: reset clears pending read data immediately
        @(negedge clk);
        ifu_req = 1; ifu_addr = 32'hFFF87FFC;
        @(negedge clk);
        idle();
        chk("R10 fetch data before reset", ifu_rdata, 32'hCAFEF00D);
        rst_n = 1'b0;
        #1;
        chk("R10 fetch data cleared by reset", ifu_rdata, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule